// File: doc/BRIEF.md
# Programmed SPI Flash Command Shifter

This block sends one short, arbitrary command to a serial NOR flash over a single-lane SPI link and collects the reply. Software fills a bank of six byte registers with the opcode and any parameter bytes, writes the total number of bits to move, and then sets a start bit. The engine pulls chip select low, clocks the bits out most significant first, and samples the data coming back into a long receive shift chain. When the last bit is done it clears the start bit, which software polls.

Outgoing bits come from the highest program register downward, so the opcode lives in the top register. Once the loaded bytes run out the engine sends zeros. Every sampled input bit enters the bottom of the receive chain and pushes older bits upward. As a result, the first byte of an L-byte transfer ends up at receive index L-1 and the last byte at index 0. The engine ignores a start request until a key value has been written to an enable register.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, SCK is low, the command register reads 0x00, every receive register reads 0x00 and the engine is locked.
- R2: A start is accepted only while unlocked. Writing 0x30 to the key register (address 0x02) unlocks the engine, and writing any other value there locks it again. A start while locked leaves bit 2 of the command register at 0 and chip select high.
- R3: Writing the command register (address 0x00) with bit 2 set starts a transfer. Bit 2 reads 1 while the transfer runs and 0 once it has finished.
- R4: The count register (address 0x01) holds the number of bits to move. A transfer produces exactly that many SCK pulses.
- R5: Transmit bits come most significant first from program register 5 (address 0x0D), then register 4, and so on down to register 0 (address 0x08). Any bit after the 48th is sent as 0.
- R6: SPI mode 0 is used. SCK idles low, MOSI changes only while SCK is low, and MISO is captured at the rising SCK edge.
- R7: Each SCK half period lasts CLK_DIV/2 clock cycles. Chip select falls CLK_DIV/2 cycles before the first rising SCK edge and rises CLK_DIV/2 cycles after the last falling SCK edge.
- R8: Each captured bit enters bit 0 of receive register 0 (address 0x10) and moves every older bit up one place. Receive register k (address 0x10+k) holds chain bits 8k+7..8k. After an 8·L-bit transfer, the first received byte is at index L-1.
- R9: A start with a count of 0 finishes at once. Bit 2 reads 0, no SCK pulse occurs and chip select stays high.
- R10: A start with a count above 64 is ignored. No transfer takes place and bit 2 stays 0.
- R11: The program registers and the count register read back the value last written to them.
- R12: Writing a program register while a transfer is running does not change the bits of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register address for reads and writes |
| regWrEn | input | 1 | One-cycle write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr |
| spiSck | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Data to the flash |
| spiMiso | input | 1 | Data from the flash |

## Verification
The main shift function is run over a table of transfers that differ in length and content:
- an opcode-only byte;
- an opcode followed by one received byte;
- a full 64-bit transfer that runs past the six loaded bytes into zero fill;
- a 40-bit mix;
- a 13-bit count that is not a whole number of bytes;
- a single bit.

Each transfer uses a distinct MISO pattern. Comparing the received registers against a running model of the chain separates a correct shift direction and byte order from reversed or non-accumulating variants. The MOSI capture separates correct register order and zero fill from wrong ones. Edge-timing monitors check lead, trail and high-phase lengths and MOSI stability while SCK is high. Directed cases cover the locked state, a re-lock, a zero count, an over-long count and rewriting a program register during a transfer.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_CMD      = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_COUNT    = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_KEY      = 5'h02;
  localparam logic [ADDR_W-1:0] ADDR_PRG_BASE = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_RX_BASE  = 5'h10;

  localparam int START_BIT = 2;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
  } shift_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL
  } shift_state_t;

endpackage

// File: rtl/spi_cmd_datapath.sv
module spi_cmd_datapath
  import spi_cmd_pkg::*;
#(
  parameter int         NUM_PRG = 6,
  parameter int         NUM_RX  = 10,
  parameter logic [7:0] KEY     = 8'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  shift_strobe_t     strobes,
  input  logic              busy,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic              startReq,
  output logic [7:0]        bitCount
);

  localparam int TX_W = 8 * NUM_PRG;
  localparam int RX_W = 8 * NUM_RX;

  logic [7:0]      prgReg [NUM_PRG];
  logic [TX_W-1:0] txLoad;
  logic [TX_W-1:0] txShift;
  logic [RX_W-1:0] rxChain;
  logic            unlocked;

  // Highest program register occupies the top byte, so it leaves first.
  always_comb begin
    txLoad = '0;
    for (int i = 0; i < NUM_PRG; i++) begin
      txLoad[8*i +: 8] = prgReg[i];
    end
  end

  assign startReq = regWrEn && (regAddr == ADDR_CMD) && regWdata[START_BIT] && unlocked;
  assign spiMosi  = txShift[TX_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PRG; i++) begin
        prgReg[i] <= '0;
      end
      bitCount <= '0;
      unlocked <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_COUNT) begin
        bitCount <= regWdata;
      end
      if (regAddr == ADDR_KEY) begin
        unlocked <= (regWdata == KEY);
      end
      for (int i = 0; i < NUM_PRG; i++) begin
        if (regAddr == ADDR_PRG_BASE + ADDR_W'(i)) begin
          prgReg[i] <= regWdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobes.loadTx) begin
      txShift <= txLoad;
    end else if (strobes.shiftTx) begin
      txShift <= {txShift[TX_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxChain <= '0;
    end else if (strobes.sampleRx) begin
      rxChain <= {rxChain[RX_W-2:0], spiMiso};
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CMD) begin
      regRdata[START_BIT] = busy;
    end
    if (regAddr == ADDR_COUNT) begin
      regRdata = bitCount;
    end
    if (regAddr == ADDR_KEY) begin
      regRdata = {7'b0, unlocked};
    end
    for (int i = 0; i < NUM_PRG; i++) begin
      if (regAddr == ADDR_PRG_BASE + ADDR_W'(i)) begin
        regRdata = prgReg[i];
      end
    end
    for (int k = 0; k < NUM_RX; k++) begin
      if (regAddr == ADDR_RX_BASE + ADDR_W'(k)) begin
        regRdata = rxChain[8*k +: 8];
      end
    end
  end

  // R8: the receive chain moves only on a sample strobe from the control
  assert_rx_hold_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sampleRx |=> $stable(rxChain));

  // R2: a start request while locked never starts a transfer
  assert_locked_no_start_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CMD && regWdata[START_BIT] && !unlocked && !busy) |=> !busy);

  // R12: the transmit shifter moves only on a strobe from the control
  assert_tx_hold_R12 : assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadTx && !strobes.shiftTx) |=> $stable(txShift));

endmodule

// File: rtl/spi_cmd_control.sv
module spi_cmd_control
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int MAX_BITS = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic [7:0]    bitCount,
  output shift_strobe_t strobes,
  output logic          busy,
  output logic          spiSck,
  output logic          spiCsN
);

  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(MAX_BITS + 1);

  shift_state_t  state;
  logic [HW-1:0] halfCnt;
  logic [BW-1:0] bitsLeft;
  logic          halfEnd;
  logic          countOk;
  logic          go;

  assign halfEnd = (halfCnt == HW'(HALF - 1));
  assign countOk = (bitCount != 8'd0) && (int'(bitCount) <= MAX_BITS);
  assign go      = (state == ST_IDLE) && startReq && countOk;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobes = '0;
    strobes.loadTx = go;
    if (halfEnd) begin
      unique case (state)
        ST_LEAD:  strobes.sampleRx = 1'b1;
        ST_LOW:   strobes.sampleRx = 1'b1;
        ST_HIGH:  strobes.shiftTx  = (bitsLeft != BW'(1));
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      bitsLeft <= '0;
      spiSck   <= 1'b0;
      spiCsN   <= 1'b1;
    end else if (state == ST_IDLE) begin
      halfCnt <= '0;
      if (go) begin
        state    <= ST_LEAD;
        bitsLeft <= BW'(bitCount);
        spiCsN   <= 1'b0;
      end
    end else if (!halfEnd) begin
      halfCnt <= halfCnt + HW'(1);
    end else begin
      halfCnt <= '0;
      unique case (state)
        ST_LEAD, ST_LOW: begin
          state  <= ST_HIGH;
          spiSck <= 1'b1;
        end
        ST_HIGH: begin
          spiSck   <= 1'b0;
          bitsLeft <= bitsLeft - BW'(1);
          state    <= (bitsLeft == BW'(1)) ? ST_TRAIL : ST_LOW;
        end
        ST_TRAIL: begin
          state  <= ST_IDLE;
          spiCsN <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: SCK never runs outside an asserted chip select
  assert_sck_in_cs_R7 : assert property (@(posedge clk) disable iff (!rstN)
    spiSck |-> !spiCsN);

  // R4: the bit counter never underflows while bits remain to be clocked
  assert_bits_left_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEAD || state == ST_HIGH || state == ST_LOW) |-> (bitsLeft != '0));

  // R9: a zero count leaves chip select high
  assert_zero_count_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && bitCount == 8'd0) |=> spiCsN);

  // R10: an over-long count leaves the engine idle
  assert_long_count_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && int'(bitCount) > MAX_BITS) |=> (state == ST_IDLE));

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int         CLK_DIV  = 4,
  parameter int         NUM_PRG  = 6,
  parameter int         NUM_RX   = 10,
  parameter int         MAX_BITS = 64,
  parameter logic [7:0] KEY      = 8'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);

  shift_strobe_t strobes;
  logic          busy;
  logic          startReq;
  logic [7:0]    bitCount;

  spi_cmd_datapath #(
    .NUM_PRG(NUM_PRG),
    .NUM_RX (NUM_RX),
    .KEY    (KEY)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .strobes (strobes),
    .busy    (busy),
    .spiMiso (spiMiso),
    .spiMosi (spiMosi),
    .startReq(startReq),
    .bitCount(bitCount)
  );

  spi_cmd_control #(
    .CLK_DIV (CLK_DIV),
    .MAX_BITS(MAX_BITS)
  ) control_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .bitCount(bitCount),
    .strobes (strobes),
    .busy    (busy),
    .spiSck  (spiSck),
    .spiCsN  (spiCsN)
  );

  // R3: whenever chip select is low, the command register reports busy
  assert_busy_in_cs_R3 : assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> busy);

endmodule

// File: tb/spi_cmd_shifter_tb_top.sv
module spi_cmd_shifter_tb_top;

  localparam int HALF = 2;

  typedef struct packed {
    logic [7:0]  cnt;
    logic [47:0] prg;
    logic [63:0] pat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd8,  48'h9F1122334455, 64'hA5F0000000000000},
    '{8'd16, 48'h050000000000, 64'h00E7000000000000},
    '{8'd64, 48'hABCDEF012345, 64'h0123456789ABCDEF},
    '{8'd40, 48'h358000000000, 64'hFFFF0000FFFF0000},
    '{8'd13, 48'h6BF000000000, 64'hDEADBEEFCAFEF00D},
    '{8'd1,  48'h800000000000, 64'h8000000000000000}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       spiSck, spiCsN, spiMosi;
  logic       spiMiso = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [63:0] curPat = '0;
  int          misoIdx = 0;
  logic [63:0] monMosi = '0;
  int          sckPulses = 0;
  int          leadCnt = 0, tailCnt = 0, highRun = 0, highErr = 0, mosiErr = 0;
  logic        pulseSeen = 1'b0;
  logic        prevMosi = 1'b0;
  logic [79:0] modelRx = '0;

  always #5 clk = ~clk;

  spi_cmd_shifter dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .spiSck(spiSck),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // Flash model: present the next pattern bit on CS fall and each SCK fall
  always @(negedge spiCsN) begin
    misoIdx = 0;
    spiMiso = curPat[63];
  end
  always @(negedge spiSck) begin
    if (!spiCsN) begin
      misoIdx = misoIdx + 1;
      if (misoIdx < 64) spiMiso = curPat[63 - misoIdx];
    end
  end

  always @(posedge spiSck) begin
    monMosi = {monMosi[62:0], spiMosi};
    sckPulses = sckPulses + 1;
  end

  // Edge-timing monitor, sampled between clock edges
  always @(negedge clk) begin
    if (!spiCsN) begin
      if (spiSck) begin
        highRun = highRun + 1;
        pulseSeen = 1'b1;
        tailCnt = 0;
        if (spiMosi !== prevMosi) mosiErr = mosiErr + 1;
      end else begin
        if (highRun != 0) begin
          if (highRun != HALF) highErr = highErr + 1;
          highRun = 0;
        end
        if (!pulseSeen) leadCnt = leadCnt + 1;
        else tailCnt = tailCnt + 1;
      end
    end
    prevMosi = spiMosi;
  end

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic clearMon();
    monMosi = '0; sckPulses = 0; leadCnt = 0; tailCnt = 0;
    highRun = 0; highErr = 0; mosiErr = 0; pulseSeen = 1'b0;
  endtask

  task automatic loadPrg(input logic [47:0] p);
    for (int i = 0; i < 6; i++) regWrite(5'h08 + 5'(i), p[8*i +: 8]);
  endtask

  task automatic waitIdle(output logic sawBusy);
    logic [7:0] d;
    sawBusy = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      regRead(5'h00, d);
      if (d[2]) sawBusy = 1'b1;
      else break;
    end
  endtask

  task automatic readRx(output logic [79:0] r);
    logic [7:0] d;
    for (int k = 0; k < 10; k++) begin
      regRead(5'h10 + 5'(k), d);
      r[8*k +: 8] = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [79:0] rx;
    logic        sawBusy;
    logic [63:0] expMosi;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 csN", {79'b0, spiCsN}, 80'd1);
    check("R1 sck", {79'b0, spiSck}, 80'd0);
    regRead(5'h00, d); check("R1 cmd", {72'b0, d}, 80'd0);
    readRx(rx); check("R1 rx", rx, 80'd0);
    regRead(5'h02, d); check("R1 locked", {72'b0, d}, 80'd0);
    rstN = 1'b1;

    // R11: readback
    regWrite(5'h01, 8'd8);
    loadPrg(48'h9F1122334455);
    regRead(5'h01, d); check("R11 count", {72'b0, d}, 80'd8);
    regRead(5'h0D, d); check("R11 prg5", {72'b0, d}, 80'h9F);
    regRead(5'h08, d); check("R11 prg0", {72'b0, d}, 80'h55);

    // R2: start while locked is ignored
    clearMon();
    regWrite(5'h00, 8'h04);
    regRead(5'h00, d); check("R2 locked busy", {72'b0, d}, 80'd0);
    repeat (4) @(negedge clk);
    check("R2 locked cs", {79'b0, spiCsN}, 80'd1);

    regWrite(5'h02, 8'h30);

    // Table of transfers: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      regWrite(5'h01, VECS[v].cnt);
      loadPrg(VECS[v].prg);
      curPat = VECS[v].pat;
      clearMon();
      regWrite(5'h00, 8'h04);
      waitIdle(sawBusy);
      repeat (2) @(negedge clk);
      for (int k = 0; k < int'(VECS[v].cnt); k++) modelRx = {modelRx[78:0], VECS[v].pat[63-k]};
      expMosi = {VECS[v].prg, 16'h0} >> (64 - int'(VECS[v].cnt));
      check("R3 busy seen", {79'b0, sawBusy}, 80'd1);
      regRead(5'h00, d); check("R3 done", {72'b0, d}, 80'd0);
      check("R4 pulses", 80'(sckPulses), 80'(VECS[v].cnt));
      check("R5 mosi", {16'b0, monMosi}, {16'b0, expMosi});
      check("R6 mosi stable", 80'(mosiErr), 80'd0);
      check("R7 lead", 80'(leadCnt), 80'(HALF));
      check("R7 tail", 80'(tailCnt), 80'(HALF));
      check("R7 high", 80'(highErr), 80'd0);
      readRx(rx); check("R8 rx", rx, modelRx);
    end

    // R8: opcode plus one byte lands reversed
    regWrite(5'h01, 8'd16);
    curPat = 64'h3C81000000000000;
    clearMon();
    regWrite(5'h00, 8'h04);
    waitIdle(sawBusy);
    regRead(5'h11, d); check("R8 first byte idx1", {72'b0, d}, 80'h3C);
    regRead(5'h10, d); check("R8 last byte idx0", {72'b0, d}, 80'h81);
    modelRx = {modelRx[63:0], 16'h3C81};

    // R2: re-lock with a wrong key
    regWrite(5'h02, 8'h31);
    clearMon();
    regWrite(5'h00, 8'h04);
    regRead(5'h00, d); check("R2 relock", {72'b0, d}, 80'd0);
    repeat (4) @(negedge clk);
    check("R2 relock pulses", 80'(sckPulses), 80'd0);
    regWrite(5'h02, 8'h30);

    // R9: zero count
    regWrite(5'h01, 8'd0);
    clearMon();
    regWrite(5'h00, 8'h04);
    regRead(5'h00, d); check("R9 zero busy", {72'b0, d}, 80'd0);
    repeat (4) @(negedge clk);
    check("R9 zero cs", {79'b0, spiCsN}, 80'd1);
    check("R9 zero pulses", 80'(sckPulses), 80'd0);

    // R10: over-long count
    regWrite(5'h01, 8'd65);
    clearMon();
    regWrite(5'h00, 8'h04);
    regRead(5'h00, d); check("R10 long busy", {72'b0, d}, 80'd0);
    repeat (4) @(negedge clk);
    check("R10 long pulses", 80'(sckPulses), 80'd0);

    // R12: rewriting a program register mid-transfer
    regWrite(5'h01, 8'd48);
    loadPrg(48'hC1C2C3C4C5C6);
    curPat = 64'h0;
    clearMon();
    regWrite(5'h00, 8'h04);
    regWrite(5'h0D, 8'h00);
    regWrite(5'h08, 8'hFF);
    waitIdle(sawBusy);
    check("R12 mosi", {16'b0, monMosi}, {32'b0, 48'hC1C2C3C4C5C6});
    regRead(5'h0D, d); check("R12 new prg5", {72'b0, d}, 80'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule